// File: doc/BRIEF.md
# Past-Time Interval Property Checker

This block decides, one step at a time, whether a trace of three proposition bits satisfies the safety property "at every step so far, whenever the interval opened by `a` and not yet closed by `b` is active, `c` holds". Each temporal sub-formula is computed from the present proposition values and a single stored value from the previous step, so the whole property costs one flip-flop per temporal operator and a few gates.

A step happens only on a cycle where `step_valid` is high; on other cycles the proposition inputs are ignored and the stored history is held. The result of each step leaves a fixed-depth output pipeline together with a valid strobe, the rising and falling edges of `a` for that step, and a sticky violation flag. The first step of the trace after reset is treated specially: every "previously" term is false there.

Top module: `ptl_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, `verdict_valid`, `verdict`, `violation`, `a_start` and `a_end` are all 0.
- R2: `verdict_valid` is high exactly 1 + `PIPE_EXTRA` cycles after each cycle with `step_valid` high and is low otherwise; when it is low, `verdict`, `a_start` and `a_end` are 0.
- R3: Proposition values presented on cycles with `step_valid` low have no effect on any later result.
- R4: On the first step after reset, "previously" of any operand is false, so the interval is active exactly when `a` is 1 and `b` is 0, and the verdict equals the implication at that step.
- R5: The interval at step n is active when `b` is 0 at step n and either `a` is 1 at step n, or `b` was 0 at step n-1 and the inner since-term was true at step n-1.
- R6: The verdict is 1 when the implication "interval active implies `c`" has held at every step since reset; after the first step where it fails the verdict stays 0 until reset.
- R7: `violation` rises in the same cycle as the first delivered verdict of 0 and then stays 1 until reset.
- R8: `a_start` is 1 for a step where `a` is 1 and was not 1 at a previous step (always 1 when `a` is 1 on the first step); `a_end` is 1 for a step where `a` is 0 and was 1 at the previous step.
- R9: Reset during a trace discards all history, so the next step is again a first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_valid | input | 1 | Marks a cycle that forms one trace step |
| prop_a | input | 1 | Proposition that opens the interval |
| prop_b | input | 1 | Proposition that closes the interval |
| prop_c | input | 1 | Proposition required while the interval is active |
| verdict_valid | output | 1 | Strobe for one delivered step result |
| verdict | output | 1 | Property satisfied up to and including that step |
| violation | output | 1 | Sticky flag: some delivered verdict was 0 |
| a_start | output | 1 | Rising edge of `prop_a` at that step |
| a_end | output | 1 | Falling edge of `prop_a` at that step |

## Verification
The assertions take no constraint on the proposition inputs: any bit pattern is a legal trace, and the only input they rely on is `step_valid`, whose history sets when a delivered result must appear. They assume the output pipeline length is small enough to track with a shift register in the checker. Random stimulus strobes `step_valid` on about six cycles in ten and biases `a`, `b` and `c` so that intervals open, run for several steps and close; a reset every few hundred cycles keeps the sticky verdict from masking later traces, and directed sequences cover the first step, steps of idle-cycle noise and a mid-trace reset.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

    // Values carried from one trace step to the next.
    typedef struct packed {
        logic first;   // no step seen yet since reset
        logic nb;      // not b at previous step
        logic since;   // inner since-term at previous step
        logic alw;     // always-term at previous step
        logic a;       // a at previous step
    } ptl_hist_t;

    // Result of one step.
    typedef struct packed {
        logic verdict;
        logic rise;
        logic fall;
    } ptl_res_t;

    // One slot of the output pipeline.
    typedef struct packed {
        logic     vld;
        ptl_res_t res;
    } ptl_stage_t;

    localparam ptl_hist_t HIST_RESET = '{first: 1'b1, nb: 1'b0, since: 1'b0, alw: 1'b1, a: 1'b0};
    localparam ptl_stage_t STAGE_IDLE = '{vld: 1'b0, res: '{verdict: 1'b0, rise: 1'b0, fall: 1'b0}};

endpackage

// File: rtl/ptl_step_eval.sv
module ptl_step_eval
    import ptl_pkg::*;
(
    input  ptl_hist_t hist_q,
    input  logic      a,
    input  logic      b,
    input  logic      c,
    output ptl_hist_t hist_next,
    output ptl_res_t  res
);

    logic prev_nb;
    logic since_now;
    logic in_interval;
    logic implied;
    logic alw_now;
    logic prev_a;

    always_comb begin
        // previously(not b): false on the first step
        prev_nb     = ~hist_q.first & hist_q.nb;
        // (previously not b) strong-since a
        since_now   = a | (prev_nb & hist_q.since);
        // strong interval [a; b)
        in_interval = ~b & since_now;
        implied     = ~in_interval | c;
        // always in the past
        alw_now     = implied & (hist_q.first | hist_q.alw);
        // edge operators on a
        prev_a      = ~hist_q.first & hist_q.a;

        res.verdict = alw_now;
        res.rise    = a & ~prev_a;
        res.fall    = ~a & prev_a;

        hist_next.first = 1'b0;
        hist_next.nb    = ~b;
        hist_next.since = since_now;
        hist_next.alw   = alw_now;
        hist_next.a     = a;
    end

endmodule

// File: rtl/ptl_history.sv
module ptl_history
    import ptl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    input  ptl_hist_t hist_next,
    output ptl_hist_t hist_q
);

    ptl_hist_t hist_d;

    always_comb begin
        hist_d = hist_q;
        if (step) begin
            hist_d = hist_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= HIST_RESET;
        end else begin
            hist_q <= hist_d;
        end
    end

endmodule

// File: rtl/ptl_delay_line.sv
module ptl_delay_line
    import ptl_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  ptl_stage_t in_s,
    output ptl_stage_t out_s
);

    generate
        if (STAGES == 0) begin : g_pass
            assign out_s = in_s;
        end else begin : g_regs
            ptl_stage_t pipe_d [STAGES];
            ptl_stage_t pipe_q [STAGES];

            always_comb begin
                pipe_d[0] = in_s;
                for (int i = 1; i < STAGES; i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) begin
                        pipe_q[i] <= STAGE_IDLE;
                    end
                end else begin
                    for (int i = 0; i < STAGES; i++) begin
                        pipe_q[i] <= pipe_d[i];
                    end
                end
            end

            assign out_s = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ptl_checker.sv
module ptl_checker
    import ptl_pkg::*;
#(
    parameter int PIPE_EXTRA = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_valid,
    input  logic prop_a,
    input  logic prop_b,
    input  logic prop_c,
    output logic verdict_valid,
    output logic verdict,
    output logic violation,
    output logic a_start,
    output logic a_end
);

    localparam int LATENCY = 1 + PIPE_EXTRA;

    typedef struct packed {
        ptl_stage_t head;
        logic       vio;
    } top_state_t;

    ptl_hist_t  hist_q;
    ptl_hist_t  hist_next;
    ptl_res_t   step_res;
    ptl_stage_t tail_s;
    top_state_t st_d;
    top_state_t st_q;

    ptl_step_eval u_eval (
        .hist_q    (hist_q),
        .a         (prop_a),
        .b         (prop_b),
        .c         (prop_c),
        .hist_next (hist_next),
        .res       (step_res)
    );

    ptl_history u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step_valid),
        .hist_next (hist_next),
        .hist_q    (hist_q)
    );

    ptl_delay_line #(.STAGES(PIPE_EXTRA)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .in_s  (st_q.head),
        .out_s (tail_s)
    );

    always_comb begin
        st_d = st_q;
        st_d.head = STAGE_IDLE;
        if (step_valid) begin
            st_d.head.vld = 1'b1;
            st_d.head.res = step_res;
        end
        st_d.vio = st_q.vio | (tail_s.vld & ~tail_s.res.verdict);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{head: STAGE_IDLE, vio: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign verdict_valid = tail_s.vld;
    assign verdict       = tail_s.res.verdict;
    assign a_start       = tail_s.res.rise;
    assign a_end         = tail_s.res.fall;
    assign violation     = st_q.vio | (tail_s.vld & ~tail_s.res.verdict);

endmodule

// File: rtl/ptl_checker_sva.sv
module ptl_checker_sva #(
    parameter int LAT = 2
) (
    input logic clk,
    input logic rst_n,
    input logic step_valid,
    input logic verdict_valid,
    input logic verdict,
    input logic violation,
    input logic a_start,
    input logic a_end
);

    logic [LAT-1:0] strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= '0;
        end else begin
            strobe_q <= {strobe_q[LAT-2:0], step_valid};
        end
    end

    AST_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n) verdict_valid == strobe_q[LAT-1]); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !verdict_valid |-> !verdict && !a_start && !a_end); // R2
    AST_VERDICT_STAYS_FALSE: assert property (@(posedge clk) disable iff (!rst_n) (verdict_valid && !verdict) |=> !(verdict_valid && verdict)); // R6
    AST_VIOLATION_STICKY: assert property (@(posedge clk) disable iff (!rst_n) violation |=> violation); // R7
    AST_VIOLATION_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(violation) |-> verdict_valid && !verdict); // R7
    AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(a_start && a_end)); // R8

endmodule

bind ptl_checker ptl_checker_sva #(.LAT(1 + PIPE_EXTRA)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_valid    (step_valid),
    .verdict_valid (verdict_valid),
    .verdict       (verdict),
    .violation     (violation),
    .a_start       (a_start),
    .a_end         (a_end)
);

// File: tb/ptl_checker_tb.sv
module ptl_checker_tb;

    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_valid = 1'b0;
    logic prop_a = 1'b0;
    logic prop_b = 1'b0;
    logic prop_c = 1'b0;
    logic verdict_valid, verdict, violation, a_start, a_end;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R5";

    // reference model state
    bit m_first, m_nb, m_since, m_alw, m_a, m_vio;
    // expected pipeline: valid, verdict, rise, fall
    bit e_v [1:LAT];
    bit e_d [1:LAT];
    bit e_r [1:LAT];
    bit e_f [1:LAT];

    always #10 clk = ~clk;

    ptl_checker #(.PIPE_EXTRA(LAT - 1)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid),
        .prop_a(prop_a), .prop_b(prop_b), .prop_c(prop_c),
        .verdict_valid(verdict_valid), .verdict(verdict), .violation(violation),
        .a_start(a_start), .a_end(a_end)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_first = 1; m_nb = 0; m_since = 0; m_alw = 1; m_a = 0; m_vio = 0;
        for (int i = 1; i <= LAT; i++) begin
            e_v[i] = 0; e_d[i] = 0; e_r[i] = 0; e_f[i] = 0;
        end
    endtask

    // Compute one step from the requirements (R4, R5, R6, R8).
    task automatic model_step(input bit a, input bit b, input bit c, output bit vd, output bit rs, output bit fl);
        bit pnb, snc, itv, alw, pa;
        pnb = !m_first && m_nb;
        snc = a || (pnb && m_since);
        itv = !b && snc;
        alw = (!itv || c) && (m_first || m_alw);
        pa  = !m_first && m_a;
        vd = alw; rs = a && !pa; fl = !a && pa;
        m_first = 0; m_nb = !b; m_since = snc; m_alw = alw; m_a = a;
    endtask

    task automatic check_outputs();
        chk("R2", "verdict_valid", verdict_valid, e_v[LAT]);
        if (e_v[LAT]) begin
            chk(tag, "verdict", verdict, e_d[LAT]);
            chk("R8", "a_start", a_start, e_r[LAT]);
            chk("R8", "a_end", a_end, e_f[LAT]);
            if (!e_d[LAT]) m_vio = 1;
        end else begin
            chk("R2", "verdict idle", verdict, 1'b0);
        end
        chk("R7", "violation", violation, m_vio);
    endtask

    task automatic cycle(input bit sv, input bit a, input bit b, input bit c);
        bit vd, rs, fl;
        @(negedge clk);
        check_outputs();
        step_valid = sv; prop_a = a; prop_b = b; prop_c = c;
        for (int i = LAT; i > 1; i--) begin
            e_v[i] = e_v[i-1]; e_d[i] = e_d[i-1]; e_r[i] = e_r[i-1]; e_f[i] = e_f[i-1];
        end
        vd = 0; rs = 0; fl = 0;
        if (sv) model_step(a, b, c, vd, rs, fl);
        e_v[1] = sv; e_d[1] = vd; e_r[1] = rs; e_f[1] = fl;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; step_valid = 0;
        model_reset();
        @(negedge clk);
        chk("R1", "valid in reset", verdict_valid, 1'b0);
        chk("R1", "verdict in reset", verdict, 1'b0);
        chk("R1", "violation in reset", violation, 1'b0);
        chk("R1", "a_start in reset", a_start, 1'b0);
        chk("R1", "a_end in reset", a_end, 1'b0);
        rst_n = 1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd5471));
        model_reset();
        do_reset();

        // R4: first step opens the interval with c low -> violation
        tag = "R4";
        cycle(1, 1, 0, 0);
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);
        do_reset();
        // R4: first step with b high keeps interval closed
        cycle(1, 1, 1, 0);
        cycle(1, 0, 0, 1);
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);

        // R5: open, hold with c, close with b, then c low outside is fine
        do_reset();
        tag = "R5";
        cycle(1, 1, 0, 1);
        cycle(1, 0, 0, 1);
        cycle(1, 0, 0, 1);
        cycle(1, 0, 1, 0);
        cycle(1, 0, 0, 0);
        cycle(1, 1, 0, 1);
        cycle(1, 0, 0, 0);
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);
        cycle(1, 0, 0, 1);
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);

        // R3: noise on idle cycles must not open an interval
        do_reset();
        tag = "R3";
        cycle(1, 0, 0, 1);
        for (int i = 0; i < 6; i++) cycle(0, 1, 0, 0);
        cycle(1, 0, 0, 0);
        cycle(0, 0, 1, 1);
        cycle(0, 1, 0, 0);
        cycle(1, 0, 0, 0);
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);

        // R9: reset mid-interval, next step is a first step
        tag = "R9";
        cycle(1, 1, 0, 1);
        cycle(1, 0, 0, 1);
        do_reset();
        cycle(1, 0, 0, 0);
        cycle(1, 0, 0, 0);
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);

        // R6: random traces with periodic reset
        tag = "R6";
        for (int n = 0; n < 4000; n++) begin
            if (n % 250 == 249) do_reset();
            cycle(($urandom % 10) < 6, ($urandom % 5) == 0, ($urandom % 4) == 0, ($urandom % 10) < 8);
        end
        for (int i = 0; i < LAT + 1; i++) cycle(0, 0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule